// File: doc/BRIEF.md
# Source-Side Link Reset Controller

This block brings the sending end of a point-to-point data link out of power-up and through its resets. It watches a raw hardware-ready level, qualifies it with a long debounce counter, and combines it with a return-path indication. That indication says the far end is sending anything other than its link-down command. When both are good, the link is declared up and the user may write. Until then, the user sees a held full flag and the transmitter is told to send link-down continuously.

There are two kinds of reset. A local reset is requested at this end. It always drops the link and keeps it down for a minimum number of cycles before the controller may come back up. A reset requested by the far end is answered without dropping the link. The controller moves to an answering state, sends the remote-reset command, pulses the CRC/framing reset for as long as the request stays, and then returns to normal operation. If the link is lost, the controller recovers on its own once readiness returns. This covers the case where this end is power-cycled.

States: POWER (after power-on), DOWN (after a local reset or link loss), UP (normal), ANSWER (replying to a far-end reset). Transitions: POWER→UP and DOWN→UP on readiness (DOWN also waits for the minimum-down timer); UP→DOWN and ANSWER→DOWN on loss of readiness; UP→ANSWER on a far-end request; ANSWER→UP when the request is removed; any state→DOWN on local reset.

Top module: `srclink_rst_ctrl`

## Requirements
- R1: While `rst_n` is low the controller is in POWER: `link_up`=0, `user_full`=1, `tx_cmd`=2'b10 (link-down), `crc_rst`=0.
- R2: The qualified hardware-ready level goes high only after `hw_ok_raw` has been sampled high on 2^FILT_BITS−1 consecutive clock edges (31 when FAST_SIM=1, 2^21−1 otherwise). A single low sample clears the qualification at once.
- R3: POWER moves to UP only when the qualified hardware-ready level and `ret_link_up` are both high. Either one alone keeps the link down.
- R4: In UP, loss of either readiness input moves to DOWN on the next edge. DOWN returns to UP by itself when both come back, with no extra wait unless a local reset started the timer.
- R5: A sampled `local_rst` moves to DOWN from any state and clears the minimum-down timer. With readiness present, `link_up` is then low for exactly MIN_DOWN (default 4) cycles.
- R6: While `local_rst` stays high, the controller stays in DOWN. The minimum-down count starts only after it is released.
- R7: In UP, a sampled `remote_rst_req` moves to ANSWER. `link_up` stays 1, `tx_cmd`=2'b01, and the controller returns to UP the edge after the request is sampled low.
- R8: `crc_rst` is high only in ANSWER.
- R9: `tx_cmd` is 2'b00 in UP, 2'b01 in ANSWER, and 2'b10 in POWER and DOWN.
- R10: `user_full` is low only in UP.
- R11: Priority: `local_rst` wins over everything. Loss of readiness wins over `remote_rst_req`. In POWER and DOWN, `remote_rst_req` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| hw_ok_raw | input | 1 | Unfiltered hardware-ready level |
| ret_link_up | input | 1 | Far end is sending a command other than link-down |
| local_rst | input | 1 | Local reset request, sampled each edge |
| remote_rst_req | input | 1 | Reset request received from the far end |
| link_up | output | 1 | Link is up (UP or ANSWER) |
| user_full | output | 1 | Full flag toward the user, held outside UP |
| tx_cmd | output | 2 | Command selection for the transmitter: 00 normal, 01 remote reset, 10 link down |
| crc_rst | output | 1 | Reset for CRC and framing logic |

## Verification
Bring-up is tried first with the hardware-ready input alone. This separates a controller that needs both readiness inputs from one that needs only the filter. A per-cycle table then walks far-end requests, held and single-cycle local resets, link loss, and combinations of these. The combinations show whether priority follows R11 and whether the minimum-down count starts on release rather than on assertion. The filter is checked last: it is cleared by one low sample and then timed to the exact edge where the link returns. That edge separates an off-by-one threshold from a correct one.

// File: rtl/srl_pkg.sv
package srl_pkg;

    typedef enum logic [1:0] {
        ST_POWER  = 2'd0,
        ST_DOWN   = 2'd1,
        ST_UP     = 2'd2,
        ST_ANSWER = 2'd3
    } srl_state_e;

    typedef enum logic [1:0] {
        CMD_NORMAL = 2'b00,
        CMD_RRST   = 2'b01,
        CMD_LDOWN  = 2'b10
    } srl_cmd_e;

endpackage

// File: rtl/srl_hwok_filter.sv
// Debounce for the hardware-ready level: qualifies after an unbroken run of
// high samples, drops in the same cycle the raw level goes low.
module srl_hwok_filter #(
    parameter int FILT_BITS = 21
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic ok
);
    logic [FILT_BITS-1:0] run_q;
    logic                 full_run;

    assign full_run = &run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (!raw) begin
            run_q <= '0;
        end else if (!full_run) begin
            run_q <= run_q + 1'b1;
        end
    end

    assign ok = raw & full_run;
endmodule

// File: rtl/srl_down_timer.sv
// Minimum link-down timer. Starts saturated so power-up and link loss do not
// wait; a local reset clears it and it counts only while running.
module srl_down_timer #(
    parameter int MIN_DOWN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic done
);
    localparam int CW = (MIN_DOWN > 2) ? $clog2(MIN_DOWN) : 1;
    localparam logic [CW-1:0] LIMIT = CW'(MIN_DOWN - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= LIMIT;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (run && (cnt_q != LIMIT)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = (cnt_q == LIMIT);
endmodule

// File: rtl/srl_fsm.sv
module srl_fsm
    import srl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       local_rst,
    input  logic       remote_req,
    input  logic       hw_ok,
    input  logic       ret_up,
    input  logic       wait_done,
    output logic       timer_run,
    output logic       link_up,
    output logic       user_full,
    output logic [1:0] tx_cmd,
    output logic       crc_rst
);
    srl_state_e state_q;
    srl_state_e state_d;
    logic       ready;

    assign ready = hw_ok & ret_up;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_POWER;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        if (local_rst) begin
            state_d = ST_DOWN;
        end else begin
            unique case (state_q)
                ST_POWER:  if (ready) state_d = ST_UP;
                ST_DOWN:   if (ready && wait_done) state_d = ST_UP;
                ST_UP: begin
                    if (!ready)          state_d = ST_DOWN;
                    else if (remote_req) state_d = ST_ANSWER;
                end
                ST_ANSWER: begin
                    if (!ready)           state_d = ST_DOWN;
                    else if (!remote_req) state_d = ST_UP;
                end
                default: state_d = ST_POWER;
            endcase
        end
    end

    // outputs
    always_comb begin
        timer_run = 1'b0;
        link_up   = 1'b0;
        user_full = 1'b1;
        tx_cmd    = CMD_LDOWN;
        crc_rst   = 1'b0;
        unique case (state_q)
            ST_POWER: begin
                tx_cmd = CMD_LDOWN;
            end
            ST_DOWN: begin
                tx_cmd    = CMD_LDOWN;
                timer_run = 1'b1;
            end
            ST_UP: begin
                link_up   = 1'b1;
                user_full = 1'b0;
                tx_cmd    = CMD_NORMAL;
            end
            ST_ANSWER: begin
                link_up = 1'b1;
                tx_cmd  = CMD_RRST;
                crc_rst = 1'b1;
            end
            default: begin
                tx_cmd = CMD_LDOWN;
            end
        endcase
    end
endmodule

// File: rtl/srclink_rst_ctrl.sv
module srclink_rst_ctrl #(
    parameter bit FAST_SIM       = 1'b0,
    parameter int FULL_FILT_BITS = 21,
    parameter int SIM_FILT_BITS  = 5,
    parameter int MIN_DOWN       = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hw_ok_raw,
    input  logic       ret_link_up,
    input  logic       local_rst,
    input  logic       remote_rst_req,
    output logic       link_up,
    output logic       user_full,
    output logic [1:0] tx_cmd,
    output logic       crc_rst
);
    localparam int FILT_BITS = FAST_SIM ? SIM_FILT_BITS : FULL_FILT_BITS;

    logic hw_ok_filt;
    logic wait_done;
    logic timer_run;

    srl_hwok_filter #(.FILT_BITS(FILT_BITS)) u_filt (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (hw_ok_raw),
        .ok    (hw_ok_filt)
    );

    srl_down_timer #(.MIN_DOWN(MIN_DOWN)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (local_rst),
        .run   (timer_run),
        .done  (wait_done)
    );

    srl_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .local_rst  (local_rst),
        .remote_req (remote_rst_req),
        .hw_ok      (hw_ok_filt),
        .ret_up     (ret_link_up),
        .wait_done  (wait_done),
        .timer_run  (timer_run),
        .link_up    (link_up),
        .user_full  (user_full),
        .tx_cmd     (tx_cmd),
        .crc_rst    (crc_rst)
    );
endmodule

// File: rtl/srclink_rst_ctrl_chk.sv
module srclink_rst_ctrl_chk #(
    parameter int MIN_DOWN = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       hw_ok_raw,
    input logic       ret_link_up,
    input logic       local_rst,
    input logic       remote_rst_req,
    input logic       link_up,
    input logic       user_full,
    input logic [1:0] tx_cmd,
    input logic       crc_rst,
    input logic       hw_ok_q
);
    localparam int SW = $clog2(MIN_DOWN + 1);

    logic          seen_q;
    logic [SW-1:0] since_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q  <= 1'b0;
            since_q <= '0;
        end else if (local_rst) begin
            seen_q  <= 1'b1;
            since_q <= '0;
        end else if (since_q != SW'(MIN_DOWN)) begin
            since_q <= since_q + 1'b1;
        end
    end

    a_r9_down_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        !link_up |-> (tx_cmd == 2'b10) && user_full && !crc_rst);

    a_r8_crc_answer: assert property (@(posedge clk) disable iff (!rst_n)
        crc_rst |-> link_up && user_full && (tx_cmd == 2'b01));

    a_r10_up_open: assert property (@(posedge clk) disable iff (!rst_n)
        (link_up && !crc_rst) |-> !user_full && (tx_cmd == 2'b00));

    a_r5_local_down: assert property (@(posedge clk) disable iff (!rst_n)
        local_rst |=> !link_up);

    a_r5_min_down: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && (since_q < SW'(MIN_DOWN))) |-> !link_up);

    a_r4_loss: assert property (@(posedge clk) disable iff (!rst_n)
        (!hw_ok_raw || !ret_link_up) |=> !link_up);

    a_r7_answer: assert property (@(posedge clk) disable iff (!rst_n)
        (link_up && !crc_rst && remote_rst_req && !local_rst && ret_link_up && hw_ok_q)
        |=> crc_rst && link_up);
endmodule

bind srclink_rst_ctrl srclink_rst_ctrl_chk #(.MIN_DOWN(MIN_DOWN)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .hw_ok_raw      (hw_ok_raw),
    .ret_link_up    (ret_link_up),
    .local_rst      (local_rst),
    .remote_rst_req (remote_rst_req),
    .link_up        (link_up),
    .user_full      (user_full),
    .tx_cmd         (tx_cmd),
    .crc_rst        (crc_rst),
    .hw_ok_q        (hw_ok_filt)
);

// File: tb/srclink_rst_ctrl_tb.sv
module srclink_rst_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hw_ok_raw = 1'b0;
    logic       ret_link_up = 1'b0;
    logic       local_rst = 1'b0;
    logic       remote_rst_req = 1'b0;
    logic       link_up;
    logic       user_full;
    logic [1:0] tx_cmd;
    logic       crc_rst;

    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    srclink_rst_ctrl #(.FAST_SIM(1'b1), .MIN_DOWN(4)) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .hw_ok_raw      (hw_ok_raw),
        .ret_link_up    (ret_link_up),
        .local_rst      (local_rst),
        .remote_rst_req (remote_rst_req),
        .link_up        (link_up),
        .user_full      (user_full),
        .tx_cmd         (tx_cmd),
        .crc_rst        (crc_rst)
    );

    // expected patterns {link_up, user_full, tx_cmd, crc_rst}
    localparam logic [4:0] E_UP   = 5'b1_0_00_0;
    localparam logic [4:0] E_ANS  = 5'b1_1_01_1;
    localparam logic [4:0] E_DOWN = 5'b0_1_10_0;

    // vector: {local_rst, remote_rst_req, hw_ok_raw, ret_link_up}, expected, requirement
    localparam int NV = 31;
    localparam logic [12:0] VEC [NV] = '{
        {4'b0011, E_UP,   4'd9},   // steady UP
        {4'b0111, E_ANS,  4'd7},   // far-end request answered
        {4'b0111, E_ANS,  4'd8},   // answer held, CRC reset on
        {4'b0011, E_UP,   4'd7},   // request removed
        {4'b0010, E_DOWN, 4'd4},   // return path lost
        {4'b0011, E_UP,   4'd4},   // self recovery, no wait
        {4'b1011, E_DOWN, 4'd5},   // local reset
        {4'b0011, E_DOWN, 4'd5},
        {4'b0011, E_DOWN, 4'd5},
        {4'b0011, E_DOWN, 4'd5},
        {4'b0011, E_UP,   4'd5},   // up after exactly 4 low cycles
        {4'b1111, E_DOWN, 4'd11},  // local reset beats far-end request
        {4'b0111, E_DOWN, 4'd11},  // far-end request ignored in DOWN
        {4'b0111, E_DOWN, 4'd11},
        {4'b0011, E_DOWN, 4'd5},
        {4'b0011, E_UP,   4'd5},
        {4'b0110, E_DOWN, 4'd11},  // loss beats far-end request
        {4'b0011, E_UP,   4'd4},
        {4'b1011, E_DOWN, 4'd6},   // held local reset
        {4'b1011, E_DOWN, 4'd6},
        {4'b1011, E_DOWN, 4'd6},
        {4'b0011, E_DOWN, 4'd6},
        {4'b0011, E_DOWN, 4'd6},
        {4'b0011, E_DOWN, 4'd6},
        {4'b0011, E_UP,   4'd6},
        {4'b0111, E_ANS,  4'd10},  // full held during answer
        {4'b1111, E_DOWN, 4'd11},  // local reset during answer
        {4'b0011, E_DOWN, 4'd5},
        {4'b0011, E_DOWN, 4'd5},
        {4'b0011, E_DOWN, 4'd5},
        {4'b0011, E_UP,   4'd5}
    };

    function automatic string rtag(input logic [3:0] n);
        case (n)
            4'd1:    return "R1";
            4'd2:    return "R2";
            4'd3:    return "R3";
            4'd4:    return "R4";
            4'd5:    return "R5";
            4'd6:    return "R6";
            4'd7:    return "R7";
            4'd8:    return "R8";
            4'd9:    return "R9";
            4'd10:   return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic chk(input string req, input logic [4:0] exp);
        logic [4:0] act;
        act = {link_up, user_full, tx_cmd, crc_rst};
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b (up,full,cmd,crc)", req, act, exp);
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #1 chk("R1", E_DOWN);
        @(negedge clk);
        rst_n = 1'b1;

        // R3: hardware ready alone does not bring the link up
        hw_ok_raw = 1'b1;
        repeat (40) @(posedge clk);
        #1 chk("R3", E_DOWN);
        @(negedge clk);
        ret_link_up = 1'b1;
        @(posedge clk);
        #1 chk("R3", E_UP);

        // table walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {local_rst, remote_rst_req, hw_ok_raw, ret_link_up} = VEC[i][12:9];
            @(posedge clk);
            #1 chk(rtag(VEC[i][3:0]), VEC[i][8:4]);
        end

        // R2: one low sample clears the filter; link returns on the 32nd edge
        @(negedge clk);
        {local_rst, remote_rst_req} = 2'b00;
        hw_ok_raw = 1'b0;
        @(posedge clk);
        #1 chk("R4", E_DOWN);
        @(negedge clk);
        hw_ok_raw = 1'b1;
        repeat (31) @(posedge clk);
        #1 chk("R2", E_DOWN);
        @(posedge clk);
        #1 chk("R2", E_UP);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule